// File: doc/BRIEF.md
# Receive FIFO Hardware Flow Controller

This block sits beside a UART receive FIFO and drives the active-low handshake outputs that tell the far-end transmitter when to send and when to pause. It watches the FIFO occupancy every cycle. When the FIFO fills past a release point, the chosen output goes HIGH so the sender holds off. When the FIFO drains to a resume point, the output goes LOW again. Between those two points the output keeps its last value, so a FIFO that hovers near a single level does not make the pin toggle.

Software chooses one of four trigger levels (1, 16, 56 or 60 bytes for a 64-byte FIFO), a 4-bit hysteresis code, which handshake pin carries the automatic control, an automatic-mode enable, and a manual level for each pin. Hysteresis code 0 places the thresholds at the neighbouring table entries. Any other code places them a symmetric byte distance above and below the programmed level. Automatic control takes effect only after software has asserted the chosen pin by hand. The other pin always follows its own manual bit.

Top module: `rxfc_flow_ctrl`

## Requirements
- R1: While reset is applied, and in the first cycle after reset with all controls at 0, `rts_n` and `dtr_n` are both HIGH and automatic mode is inactive.
- R2: Both outputs are registered. Every input change shows at the pins after exactly one rising clock edge.
- R3: `pair_sel` = 0 gives automatic control to `rts_n`. `pair_sel` = 1 gives it to `dtr_n`.
- R4: The pin not chosen by `pair_sel` always equals the inverse of its own manual bit (`man_rts` for `rts_n`, `man_dtr` for `dtr_n`), whatever the FIFO count.
- R5: Automatic mode is active only when `auto_en` = 1 and the manual bit of the chosen pin is 1. Otherwise the chosen pin equals the inverse of its manual bit.
- R6: With hysteresis code 0, reaching the programmed level does not release the pin. The pin goes HIGH when `fifo_count` is at or above the next table level up (`trig_sel` 0..3 selects 1, 16, 56, 60).
- R7: With hysteresis code 0, a released pin goes LOW again when `fifo_count` is at or below the next table level down, or at or below 0 when `trig_sel` = 0.
- R8: With `trig_sel` = 3 and hysteresis code 0, the release point saturates at 60 and the resume point is 56.
- R9: With hysteresis code n from 1 to 15, the offset is min(4·2^(n−1), 64). Release is at min(level+offset, 64) and resume is at max(level−offset, 0).
- R10: While `fifo_count` lies strictly between the resume and release points, the chosen pin holds its value, both while the FIFO fills and while it drains.
- R11: Leaving automatic mode clears the paused state. When automatic mode starts again with the count between the thresholds, the pin is LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_count | input | 7 | Current receive FIFO occupancy, 0 to 64 |
| trig_sel | input | 2 | Programmed trigger level index (0:1, 1:16, 2:56, 3:60) |
| hyst_code | input | 4 | Hysteresis code: 0 uses table neighbours, 1..15 a byte offset |
| pair_sel | input | 1 | 0 chooses the RTS pin, 1 the DTR pin, for automatic control |
| auto_en | input | 1 | Automatic flow control enable |
| man_rts | input | 1 | Manual RTS level, 1 asserts (drives LOW) |
| man_dtr | input | 1 | Manual DTR level, 1 asserts (drives LOW) |
| rts_n | output | 1 | Active-low request-to-send pin |
| dtr_n | output | 1 | Active-low data-terminal-ready pin |

## Verification
Every result has a latency of one cycle. The pin value for a given count and set of controls is taken at one rising edge and appears after it. The bench changes inputs on the falling edge and reads the pins on the next falling edge, which is exactly one rising edge later. Each count step is applied for a single cycle and checked at once, including the steps just below and exactly on each threshold. This shows directly whether the pin moved or held in that cycle.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    typedef enum logic {
        PAIR_RTS = 1'b0,
        PAIR_DTR = 1'b1
    } pair_e;

    // Symmetric hysteresis distance for a nonzero code: base doubled (code-1) times, capped at lim
    function automatic int unsigned hyst_offset(input int unsigned base,
                                                input int unsigned code,
                                                input int unsigned lim);
        int unsigned acc;
        acc = base;
        for (int unsigned k = 1; k < 16; k++) begin
            if (k < code && acc < lim) acc = acc * 2;
        end
        if (acc > lim) acc = lim;
        return acc;
    endfunction

endpackage

// File: rtl/rxfc_thresh.sv
module rxfc_thresh
    import rxfc_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 64,
    parameter int unsigned NUM_LVL    = 4,
    parameter int unsigned HYST_BASE  = 4,
    parameter int unsigned TRIG_LVL [NUM_LVL] = '{1, 16, 56, 60},
    parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1),
    parameter int unsigned SEL_W      = $clog2(NUM_LVL),
    parameter int unsigned CODE_W     = 4
) (
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic [CODE_W-1:0] hyst_code,
    output logic [CNT_W-1:0]  release_at,
    output logic [CNT_W-1:0]  resume_at
);

    logic [CNT_W-1:0] lvl_tab  [NUM_LVL];
    logic [CNT_W-1:0] up_tab   [NUM_LVL];
    logic [CNT_W-1:0] down_tab [NUM_LVL];

    // Neighbour tables, saturating at both ends of the level list
    for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
        assign lvl_tab[i] = CNT_W'(TRIG_LVL[i]);
        if (i == NUM_LVL - 1) begin : g_top
            assign up_tab[i] = CNT_W'(TRIG_LVL[i]);
        end else begin : g_mid_up
            assign up_tab[i] = CNT_W'(TRIG_LVL[i+1]);
        end
        if (i == 0) begin : g_bottom
            assign down_tab[i] = '0;
        end else begin : g_mid_dn
            assign down_tab[i] = CNT_W'(TRIG_LVL[i-1]);
        end
    end

    int unsigned off;
    int unsigned lvl;
    int unsigned hi;

    always_comb begin
        lvl = int'(lvl_tab[trig_sel]);
        off = hyst_offset(HYST_BASE, int'(hyst_code), FIFO_DEPTH);
        hi  = lvl + off;
        if (hi > FIFO_DEPTH) hi = FIFO_DEPTH;
        if (hyst_code == '0) begin
            release_at = up_tab[trig_sel];
            resume_at  = down_tab[trig_sel];
        end else begin
            release_at = CNT_W'(hi);
            resume_at  = (lvl > off) ? CNT_W'(lvl - off) : '0;
        end
    end

endmodule

// File: rtl/rxfc_gate.sv
module rxfc_gate #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] release_at,
    input  logic [CNT_W-1:0] resume_at,
    output logic             pause_nxt,
    output logic             pause_q
);

    typedef struct packed {
        logic paused;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!active) begin
            st_d.paused = 1'b0;
        end else if (fifo_count >= release_at) begin
            st_d.paused = 1'b1;
        end else if (fifo_count <= resume_at) begin
            st_d.paused = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pause_nxt = st_d.paused;
    assign pause_q   = st_q.paused;

    // R6 / R9: reaching the release point pauses the sender
    assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fifo_count >= release_at) |=> pause_q);

    // R7: draining below the release point to the resume point clears the pause
    assert_resume_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fifo_count < release_at && fifo_count <= resume_at) |=> !pause_q);

    // R10: the band strictly between the thresholds keeps the state
    assert_hold_band_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && fifo_count > resume_at && fifo_count < release_at) |=> $stable(pause_q));

    // R11: inactive mode leaves no pending pause
    assert_exit_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !pause_q);

endmodule

// File: rtl/rxfc_flow_ctrl.sv
module rxfc_flow_ctrl
    import rxfc_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 64,
    parameter int unsigned NUM_LVL    = 4,
    parameter int unsigned HYST_BASE  = 4,
    parameter int unsigned TRIG_LVL [NUM_LVL] = '{1, 16, 56, 60},
    parameter int unsigned CODE_W     = 4,
    localparam int unsigned CNT_W     = $clog2(FIFO_DEPTH + 1),
    localparam int unsigned SEL_W     = $clog2(NUM_LVL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [SEL_W-1:0]  trig_sel,
    input  logic [CODE_W-1:0] hyst_code,
    input  logic              pair_sel,
    input  logic              auto_en,
    input  logic              man_rts,
    input  logic              man_dtr,
    output logic              rts_n,
    output logic              dtr_n
);

    typedef struct packed {
        logic rts_n;
        logic dtr_n;
    } pin_st_t;

    pin_st_t pin_d, pin_q;

    logic [CNT_W-1:0] release_at, resume_at;
    logic             man_sel, auto_on, pause_nxt, pause_q;
    logic             rts_auto, dtr_auto;

    rxfc_thresh #(
        .FIFO_DEPTH (FIFO_DEPTH),
        .NUM_LVL    (NUM_LVL),
        .HYST_BASE  (HYST_BASE),
        .TRIG_LVL   (TRIG_LVL),
        .CNT_W      (CNT_W),
        .SEL_W      (SEL_W),
        .CODE_W     (CODE_W)
    ) u_thresh (
        .trig_sel   (trig_sel),
        .hyst_code  (hyst_code),
        .release_at (release_at),
        .resume_at  (resume_at)
    );

    rxfc_gate #(
        .CNT_W (CNT_W)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (auto_on),
        .fifo_count (fifo_count),
        .release_at (release_at),
        .resume_at  (resume_at),
        .pause_nxt  (pause_nxt),
        .pause_q    (pause_q)
    );

    always_comb begin
        man_sel  = (pair_sel == PAIR_DTR) ? man_dtr : man_rts;
        auto_on  = auto_en && man_sel;
        rts_auto = auto_on && (pair_sel == PAIR_RTS);
        dtr_auto = auto_on && (pair_sel == PAIR_DTR);

        pin_d       = pin_q;
        pin_d.rts_n = rts_auto ? pause_nxt : !man_rts;
        pin_d.dtr_n = dtr_auto ? pause_nxt : !man_dtr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '{rts_n: 1'b1, dtr_n: 1'b1};
        else        pin_q <= pin_d;
    end

    assign rts_n = pin_q.rts_n;
    assign dtr_n = pin_q.dtr_n;

    // R1: pins leave reset de-asserted
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rts_n && dtr_n && !pause_q));

    // R4: the pin outside automatic control mirrors its manual bit
    assert_unsel_rts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_sel == PAIR_DTR) |=> (rts_n == !$past(man_rts)));
    assert_unsel_dtr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_sel == PAIR_RTS) |=> (dtr_n == !$past(man_dtr)));

    // R5: without automatic start the chosen pin is manual
    assert_manual_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_on && pair_sel == PAIR_RTS) |=> (rts_n == !$past(man_rts)));

    // R3: the chosen pin carries the pause decision one cycle later
    assert_pair_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_on && pair_sel == PAIR_DTR) |=> (dtr_n == pause_q));

    // R9: thresholds stay ordered and inside the FIFO range
    assert_thresh_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (release_at <= CNT_W'(FIFO_DEPTH)) && (resume_at <= release_at));

endmodule

// File: tb/rxfc_flow_ctrl_bench.sv
`timescale 1ns/1ps
module rxfc_flow_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] fifo_count;
    logic [1:0] trig_sel;
    logic [3:0] hyst_code;
    logic       pair_sel, auto_en, man_rts, man_dtr;
    logic       rts_n, dtr_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    rxfc_flow_ctrl u_rxfc_flow_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_count (fifo_count),
        .trig_sel   (trig_sel),
        .hyst_code  (hyst_code),
        .pair_sel   (pair_sel),
        .auto_en    (auto_en),
        .man_rts    (man_rts),
        .man_dtr    (man_dtr),
        .rts_n      (rts_n),
        .dtr_n      (dtr_n)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Apply a count at the falling edge, then wait one rising edge
    task automatic step(input int cnt);
        fifo_count = 7'(cnt);
        @(negedge clk);
    endtask

    task automatic idle_auto();
        auto_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; fifo_count = '0; trig_sel = '0; hyst_code = '0;
        pair_sel = 1'b0; auto_en = 1'b0; man_rts = 1'b0; man_dtr = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "rts_n in reset", rts_n, 1'b1);
        check("R1", "dtr_n in reset", dtr_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rts_n after reset", rts_n, 1'b1);
        check("R1", "dtr_n after reset", dtr_n, 1'b1);
    endtask

    task automatic t_manual();
        man_rts = 1'b1; @(negedge clk);
        check("R2", "rts_n manual assert", rts_n, 1'b0);
        man_dtr = 1'b1; @(negedge clk);
        check("R4", "dtr_n unselected manual", dtr_n, 1'b0);
        man_rts = 1'b0; man_dtr = 1'b0; @(negedge clk);
        check("R2", "rts_n manual release", rts_n, 1'b1);
        check("R4", "dtr_n unselected release", dtr_n, 1'b1);
    endtask

    task automatic t_start_gate();
        trig_sel = 2'd1; hyst_code = 4'd0; pair_sel = 1'b0;
        auto_en = 1'b1; man_rts = 1'b0;
        step(0);
        check("R5", "auto without manual start stays HIGH", rts_n, 1'b1);
        man_rts = 1'b1;
        step(0);
        check("R5", "auto started, empty FIFO", rts_n, 1'b0);
    endtask

    task automatic t_table_mid();
        idle_auto();
        trig_sel = 2'd1; hyst_code = 4'd0; pair_sel = 1'b0;
        man_rts = 1'b1; auto_en = 1'b1;
        step(16); check("R6", "at programmed level 16", rts_n, 1'b0);
        step(55); check("R10", "fill band 55", rts_n, 1'b0);
        step(56); check("R6", "release at next level 56", rts_n, 1'b1);
        step(30); check("R10", "drain band 30", rts_n, 1'b1);
        step(2);  check("R10", "drain band 2", rts_n, 1'b1);
        step(1);  check("R7", "resume at level 1", rts_n, 1'b0);
        step(40); check("R10", "refill band 40", rts_n, 1'b0);
    endtask

    task automatic t_table_low();
        idle_auto();
        trig_sel = 2'd0; hyst_code = 4'd0; auto_en = 1'b1;
        step(15); check("R6", "low level below 16", rts_n, 1'b0);
        step(16); check("R6", "low level release 16", rts_n, 1'b1);
        step(1);  check("R7", "low level hold at 1", rts_n, 1'b1);
        step(0);  check("R7", "low level resume at 0", rts_n, 1'b0);
    endtask

    task automatic t_table_top();
        idle_auto();
        trig_sel = 2'd3; hyst_code = 4'd0; auto_en = 1'b1;
        step(59); check("R8", "top below 60", rts_n, 1'b0);
        step(60); check("R8", "top release 60", rts_n, 1'b1);
        step(57); check("R8", "top hold 57", rts_n, 1'b1);
        step(56); check("R8", "top resume 56", rts_n, 1'b0);
    endtask

    task automatic t_offset();
        idle_auto();
        trig_sel = 2'd1; hyst_code = 4'd2; auto_en = 1'b1;  // offset 8: 24 / 8
        step(23); check("R9", "code2 below 24", rts_n, 1'b0);
        step(24); check("R9", "code2 release 24", rts_n, 1'b1);
        step(9);  check("R10", "code2 hold 9", rts_n, 1'b1);
        step(8);  check("R9", "code2 resume 8", rts_n, 1'b0);
        idle_auto();
        trig_sel = 2'd2; hyst_code = 4'd4; auto_en = 1'b1;  // offset 32: 64 / 24
        step(63); check("R9", "code4 below 64", rts_n, 1'b0);
        step(64); check("R9", "code4 release clamp 64", rts_n, 1'b1);
        step(25); check("R10", "code4 hold 25", rts_n, 1'b1);
        step(24); check("R9", "code4 resume 24", rts_n, 1'b0);
        idle_auto();
        trig_sel = 2'd0; hyst_code = 4'd1; auto_en = 1'b1;  // offset 4: 5 / 0
        step(5);  check("R9", "code1 release 5", rts_n, 1'b1);
        step(1);  check("R9", "code1 hold 1", rts_n, 1'b1);
        step(0);  check("R9", "code1 resume clamp 0", rts_n, 1'b0);
    endtask

    task automatic t_dtr_pair();
        idle_auto();
        trig_sel = 2'd1; hyst_code = 4'd0; pair_sel = 1'b1;
        man_dtr = 1'b1; man_rts = 1'b0; auto_en = 1'b1;
        step(56);
        check("R3", "dtr_n released at 56", dtr_n, 1'b1);
        check("R4", "rts_n unselected not auto", rts_n, 1'b1);
        man_rts = 1'b1;
        step(60);
        check("R4", "rts_n follows manual at 60", rts_n, 1'b0);
        step(1);
        check("R3", "dtr_n resumed at 1", dtr_n, 1'b0);
        pair_sel = 1'b0; man_dtr = 1'b0;
    endtask

    task automatic t_exit();
        idle_auto();
        trig_sel = 2'd1; hyst_code = 4'd0; man_rts = 1'b1; auto_en = 1'b1;
        step(60); check("R11", "paused before exit", rts_n, 1'b1);
        auto_en = 1'b0;
        step(60); check("R11", "manual after exit", rts_n, 1'b0);
        auto_en = 1'b1;
        step(30); check("R11", "re-entry in band LOW", rts_n, 1'b0);
    endtask

    initial begin
        t_reset();
        t_manual();
        t_start_gate();
        t_table_mid();
        t_table_low();
        t_table_top();
        t_offset();
        t_dtr_pair();
        t_exit();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule